// File: doc/BRIEF.md
# Display Bridge Bring-up Sequencer

This block powers up an RGB-to-serial display bridge and loads its start-up configuration. A start pulse removes power, then walks a timed power and reset ramp counted in millisecond ticks. After that it issues eighteen register writes, one at a time, through a simple request/done interface. The write values come from the panel timing inputs, the pixel format code and the lane count. The PLL word and the low-power clock divider arrive ready-made from another unit.

After a fixed settling pause it writes the final link configuration and raises `ready`. `ready` stays high until the next start. The serial transport that carries each write, and the PLL arithmetic, sit outside this block.

Top module: `bridge_bringup_seq`

## Requirements
- R1: After reset, and until the first start, `pwr_en`=0, `rst_out_n`=1, `wr_req`=0 and `ready`=0. A `wr_done` pulse in this state changes none of them.
- R2: A start sampled at a clock edge puts the block in a power-off state for one cycle: `pwr_en`=0, `rst_out_n`=1, `wr_req`=0, `ready`=0. This happens from any state, including mid-write and ready. In the following cycle `pwr_en` rises.
- R3: With power on, `rst_out_n` falls on the WAIT_MS-th `ms_tick` and rises on the next WAIT_MS-th tick. The first write request appears on the WAIT_MS-th tick after that. A `wr_done` pulse during these waits is ignored. `rst_out_n` is low only while `pwr_en` is high.
- R4: `wr_req` stays high with an unchanged `wr_addr` until a cycle with `wr_done` high. The next write of the list is presented in the cycle after that done. `wr_req` is high only while power is on and reset is released.
- R5: Writes 0 to 3 are: 0xC0←0x0100; 0xB1←{vsync width, hsync width}; 0xB2←{vsync+vbp, hsync+hbp}; 0xB3←{vfp, hfp}. The high byte is listed first. Each sum is taken modulo 256.
- R6: Writes 4 to 6 are: 0xB4←active width; 0xB5←active height; 0xB6←0xE004 OR (3 − format), where the format is a 2-bit code.
- R7: Writes 7 and 8 are: 0xDE←lanes − 1, then 0xD6←0x0004.
- R8: Writes 9 to 15 are, in order: 0xB9←0, 0xC4←1, 0xC9←0x2103, 0xBA←PLL word, 0xBB←low-power divider, 0xB9←1, 0xB8←0.
- R9: After write 15 completes, `wr_req` stays low until the WAIT_MS-th `ms_tick`. The block then writes 0xB7←0x0342, followed by 0xB8←0.
- R10: `ready` rises in the cycle after the done of write 17. It then holds, with `pwr_en`=1, `rst_out_n`=1 and `wr_req`=0, until the next start. `wr_done` in this state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart the whole bring-up from power-off |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| hsync_w | input | 8 | Horizontal sync width |
| hbp | input | 8 | Horizontal back porch |
| hfp | input | 8 | Horizontal front porch |
| vsync_w | input | 8 | Vertical sync width |
| vbp | input | 8 | Vertical back porch |
| vfp | input | 8 | Vertical front porch |
| h_active | input | 16 | Active width in pixels |
| v_active | input | 16 | Active height in lines |
| pix_fmt | input | 2 | Pixel format code |
| lanes | input | 3 | Number of serial lanes (1 to 4) |
| pll_word | input | 16 | Precomputed PLL configuration word |
| lp_div | input | 16 | Precomputed low-power clock divider word |
| pwr_en | output | 1 | Bridge power enable |
| rst_out_n | output | 1 | Bridge reset, active low |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 8 | Register address of the pending write |
| wr_data | output | 16 | Data of the pending write |
| wr_done | input | 1 | Downstream finished the pending write |
| ready | output | 1 | Bring-up complete |

## Verification
The timing sums are driven to values that pass 255. A design that kept a carry or widened the sum would then put a wrong byte into the porch register. Format code 0 and a single lane test the subtraction edges. A wrong subtraction there would show up as bad low bits in the mode word or the lane word.

Every wait is probed one tick early and again on the exact tick. This catches an off-by-one in the tick counter, which would move a reset edge or the first write. A start is also issued in the middle of the write list. A design that resumed the list, or never dropped power, would then issue something other than the soft reset as its first write.

Stray done pulses are sent while idle, while waiting and while ready. A design that advanced on an unrequested done would skip a register.

// File: rtl/bridge_bringup_seq.sv
module bridge_bringup_seq #(
  parameter int WAIT_MS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ms_tick,
  input  logic [7:0]  hsync_w,
  input  logic [7:0]  hbp,
  input  logic [7:0]  hfp,
  input  logic [7:0]  vsync_w,
  input  logic [7:0]  vbp,
  input  logic [7:0]  vfp,
  input  logic [15:0] h_active,
  input  logic [15:0] v_active,
  input  logic [1:0]  pix_fmt,
  input  logic [2:0]  lanes,
  input  logic [15:0] pll_word,
  input  logic [15:0] lp_div,
  output logic        pwr_en,
  output logic        rst_out_n,
  output logic        wr_req,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  input  logic        wr_done,
  output logic        ready
);
  localparam int CW     = $clog2(WAIT_MS + 1);
  localparam int NWR    = 18;
  localparam int GAP_AT = 16;
  localparam int IW     = $clog2(NWR);
  localparam logic [CW-1:0] WLAST = CW'(WAIT_MS - 1);

  typedef enum logic [2:0] {S_IDLE, S_OFF, S_PWR, S_RLO, S_RHI, S_WR, S_GAP, S_RDY} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          waiting, wait_end, wr_fire;

  assign waiting   = (st == S_PWR) || (st == S_RLO) || (st == S_RHI) || (st == S_GAP);
  assign wait_end  = waiting && ms_tick && (cnt == WLAST);
  assign wr_fire   = (st == S_WR) && wr_done;

  assign pwr_en    = (st != S_IDLE) && (st != S_OFF);
  assign rst_out_n = (st != S_RLO);
  assign wr_req    = (st == S_WR);
  assign ready     = (st == S_RDY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
    end else if (start) begin
      st  <= S_OFF;
      cnt <= '0;
      idx <= '0;
    end else begin
      if (waiting && ms_tick) cnt <= wait_end ? '0 : cnt + 1'b1;
      if (wr_fire) idx <= idx + 1'b1;
      case (st)
        S_OFF: st <= S_PWR;
        S_PWR: if (wait_end) st <= S_RLO;
        S_RLO: if (wait_end) st <= S_RHI;
        S_RHI: if (wait_end) st <= S_WR;
        S_WR:
          if (wr_fire) begin
            if (idx == IW'(GAP_AT - 1)) st <= S_GAP;
            else if (idx == IW'(NWR - 1)) st <= S_RDY;
          end
        S_GAP: if (wait_end) st <= S_WR;
        default: ;
      endcase
    end
  end

  always_comb begin
    wr_addr = 8'h00;
    wr_data = 16'h0000;
    case (idx)
      5'd0:  begin wr_addr = 8'hC0; wr_data = 16'h0100; end
      5'd1:  begin wr_addr = 8'hB1; wr_data = {vsync_w, hsync_w}; end
      5'd2:  begin wr_addr = 8'hB2; wr_data = {8'(vsync_w + vbp), 8'(hsync_w + hbp)}; end
      5'd3:  begin wr_addr = 8'hB3; wr_data = {vfp, hfp}; end
      5'd4:  begin wr_addr = 8'hB4; wr_data = h_active; end
      5'd5:  begin wr_addr = 8'hB5; wr_data = v_active; end
      5'd6:  begin wr_addr = 8'hB6; wr_data = 16'hE004 | {14'd0, 2'd3 - pix_fmt}; end
      5'd7:  begin wr_addr = 8'hDE; wr_data = {13'd0, lanes - 3'd1}; end
      5'd8:  begin wr_addr = 8'hD6; wr_data = 16'h0004; end
      5'd9:  begin wr_addr = 8'hB9; wr_data = 16'h0000; end
      5'd10: begin wr_addr = 8'hC4; wr_data = 16'h0001; end
      5'd11: begin wr_addr = 8'hC9; wr_data = 16'h2103; end
      5'd12: begin wr_addr = 8'hBA; wr_data = pll_word; end
      5'd13: begin wr_addr = 8'hBB; wr_data = lp_div; end
      5'd14: begin wr_addr = 8'hB9; wr_data = 16'h0001; end
      5'd15: begin wr_addr = 8'hB8; wr_data = 16'h0000; end
      5'd16: begin wr_addr = 8'hB7; wr_data = 16'h0342; end
      5'd17: begin wr_addr = 8'hB8; wr_data = 16'h0000; end
      default: ;
    endcase
  end

  assert_start_powers_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!pwr_en && !ready && !wr_req));

  assert_reset_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> pwr_en);

  assert_req_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_done && !start) |=> (wr_req && $stable(wr_addr)));

  assert_req_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (pwr_en && rst_out_n));

  assert_ready_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> (ready && pwr_en && rst_out_n && !wr_req));
endmodule

// File: tb/tb_bridge_bringup_seq.sv
module tb_bridge_bringup_seq;
  localparam int WAIT_MS = 10;

  typedef struct packed {
    logic [7:0]  hs, hbp, hfp, vs, vbp, vfp;
    logic [15:0] hact, vact;
    logic [1:0]  fmt;
    logic [2:0]  ln;
    logic [15:0] pll, lpd;
  } cfg_t;

  localparam cfg_t CFGS [2] = '{
    '{hs:8'd10,  hbp:8'd20,  hfp:8'd30,  vs:8'd2,   vbp:8'd8,  vfp:8'd12,
      hact:16'd480,  vact:16'd800, fmt:2'd3, ln:3'd4, pll:16'h8C1E, lpd:16'h0003},
    '{hs:8'd200, hbp:8'd100, hfp:8'd255, vs:8'd250, vbp:8'd10, vfp:8'd0,
      hact:16'd1366, vact:16'd768, fmt:2'd0, ln:3'd1, pll:16'hC21F, lpd:16'h003F}
  };

  logic clk = 0, rst_n = 0, start = 0, ms_tick = 0, wr_done = 0;
  logic [7:0] hsync_w, hbp, hfp, vsync_w, vbp, vfp;
  logic [15:0] h_active, v_active, pll_word, lp_div;
  logic [1:0] pix_fmt;
  logic [2:0] lanes;
  logic pwr_en, rst_out_n, wr_req, ready;
  logic [7:0] wr_addr;
  logic [15:0] wr_data;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  bridge_bringup_seq #(.WAIT_MS(WAIT_MS)) dut (
    .clk, .rst_n, .start, .ms_tick, .hsync_w, .hbp, .hfp, .vsync_w, .vbp, .vfp,
    .h_active, .v_active, .pix_fmt, .lanes, .pll_word, .lp_div,
    .pwr_en, .rst_out_n, .wr_req, .wr_addr, .wr_data, .wr_done, .ready);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expw(int i, cfg_t c);
    case (i)
      0:  return {8'hC0, 16'h0100};
      1:  return {8'hB1, c.vs, c.hs};
      2:  return {8'hB2, 8'((c.vs + c.vbp) % 256), 8'((c.hs + c.hbp) % 256)};
      3:  return {8'hB3, c.vfp, c.hfp};
      4:  return {8'hB4, c.hact};
      5:  return {8'hB5, c.vact};
      6:  return {8'hB6, 16'hE004 | 16'(3 - c.fmt)};
      7:  return {8'hDE, 16'(c.ln - 1)};
      8:  return {8'hD6, 16'h0004};
      9:  return {8'hB9, 16'h0000};
      10: return {8'hC4, 16'h0001};
      11: return {8'hC9, 16'h2103};
      12: return {8'hBA, c.pll};
      13: return {8'hBB, c.lpd};
      14: return {8'hB9, 16'h0001};
      15: return {8'hB8, 16'h0000};
      16: return {8'hB7, 16'h0342};
      default: return {8'hB8, 16'h0000};
    endcase
  endfunction

  function automatic string tag(int i);
    if (i < 4) return "R5";
    if (i < 7) return "R6";
    if (i < 9) return "R7";
    if (i < 16) return "R8";
    return "R9";
  endfunction

  task automatic apply(cfg_t c);
    hsync_w = c.hs; hbp = c.hbp; hfp = c.hfp; vsync_w = c.vs; vbp = c.vbp; vfp = c.vfp;
    h_active = c.hact; v_active = c.vact; pix_fmt = c.fmt; lanes = c.ln;
    pll_word = c.pll; lp_div = c.lpd;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ms_tick = 1;
      @(negedge clk) ms_tick = 0;
    end
  endtask

  task automatic pulse_done;
    @(negedge clk) wr_done = 1;
    @(negedge clk) wr_done = 0;
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R2 power off", {pwr_en, rst_out_n, wr_req, ready}, 4'b0100);
  endtask

  task automatic do_write(int i, cfg_t c);
    chk({tag(i), " req"}, wr_req, 1'b1);
    chk({tag(i), " word"}, {wr_addr, wr_data}, expw(i, c));
    @(negedge clk);
    chk("R4 held", {wr_req, wr_addr}, {1'b1, expw(i, c)[23:16]});
    pulse_done();
  endtask

  task automatic power_ramp;
    @(negedge clk);
    chk("R2 power on", {pwr_en, rst_out_n}, 2'b11);
    ticks(WAIT_MS - 1);
    chk("R3 reset not yet", rst_out_n, 1'b1);
    pulse_done();
    ticks(1);
    chk("R3 reset low", {pwr_en, rst_out_n}, 2'b10);
    ticks(WAIT_MS - 1);
    chk("R3 reset still low", rst_out_n, 1'b0);
    ticks(1);
    chk("R3 reset released", {rst_out_n, wr_req}, 2'b10);
    ticks(WAIT_MS - 1);
    chk("R3 no early write", wr_req, 1'b0);
    ticks(1);
  endtask

  task automatic run_seq(cfg_t c);
    apply(c);
    pulse_start();
    power_ramp();
    for (int i = 0; i < 16; i++) do_write(i, c);
    chk("R9 gap idle", wr_req, 1'b0);
    ticks(WAIT_MS - 1);
    chk("R9 gap still idle", wr_req, 1'b0);
    ticks(1);
    for (int i = 16; i < 18; i++) do_write(i, c);
    chk("R10 ready", {ready, pwr_en, rst_out_n, wr_req}, 4'b1110);
    pulse_done();
    ticks(2);
    chk("R10 ready holds", {ready, wr_req}, 2'b10);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    apply(CFGS[0]);
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {pwr_en, rst_out_n, wr_req, ready}, 4'b0100);
    rst_n = 1;
    pulse_done();
    ticks(3);
    chk("R1 idle ignores done", {pwr_en, rst_out_n, wr_req, ready}, 4'b0100);

    for (int s = 0; s < 2; s++) run_seq(CFGS[s]);

    apply(CFGS[1]);
    pulse_start();
    power_ramp();
    for (int i = 0; i < 3; i++) do_write(i, CFGS[1]);
    pulse_start();
    apply(CFGS[0]);
    power_ramp();
    chk("R2 restart begins list", {wr_addr, wr_data}, expw(0, CFGS[0]));

    run_seq(CFGS[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule